// File: doc/BRIEF.md
# Three-Channel Compare-Match Tick Timer

The block keeps three free-running tick counters: one for the processor, one for the system and one for the hypervisor. Each counter holds a 63-bit value. It advances by one on every cycle in which the period strobe `tick_en` is high, and it wraps to zero after its largest value. Each counter has a 64-bit compare register. Bit 63 of that register is an interrupt-disable flag, and bits 62:0 hold the match value.

When a counted tick brings a counter onto its compare value and the disable flag is clear, the block responds in a way that depends on the channel:

- The processor channel sets soft-interrupt bit 0 and pulses the timer interrupt.
- The system channel sets soft-interrupt bit 16 and pulses the timer interrupt.
- The hypervisor channel only pulses the timer interrupt.

Software writes and reads the six registers through one flat address port. It clears soft-interrupt bits through a separate clear port that takes a mask.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, all three counters read 0, all three compare registers read 0x8000_0000_0000_0000, `softint` is 0 and `timer_irq` is low.
- R2: In each cycle with `tick_en` high and no write to a counter, that counter increments by one at the clock edge. Without `tick_en` it holds its value. A counter always reads back with bit 63 at zero, and a write loads only bits 62:0.
- R3: A counter at 0x7FFF_FFFF_FFFF_FFFF steps to 0 on its next counted tick.
- R4: The register addresses are 0, 1 and 2 for the processor, system and hypervisor counters, and 4, 5 and 6 for their compare registers. Addresses 3 and 7 read as zero, and writes to them change nothing.
- R5: A counter write loads the new value at that edge. If a tick arrives in the same cycle, the write wins: the tick is not counted and cannot produce a match.
- R6: A match occurs when a counted tick makes the counter's bits 62:0 equal the compare bits 62:0 while compare bit 63 is clear. Its effects appear at the same edge as the counter update.
- R7: While compare bit 63 is set, reaching the compare value sets no soft-interrupt bit and raises no timer interrupt.
- R8: A processor-channel match sets `softint` bit 0 and raises `timer_irq`.
- R9: A system-channel match sets `softint` bit 16 and raises `timer_irq`.
- R10: A hypervisor-channel match raises `timer_irq` and leaves `softint` unchanged.
- R11: `timer_irq` is high for exactly the one cycle that follows each edge with a match, and low in every other cycle.
- R12: A compare write takes effect from the next count. A tick in the same cycle as the compare write is checked against the old compare value.
- R13: When `clr_en` is high, every `softint` bit whose `clr_mask` bit is 1 is cleared. A match that sets the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Period strobe; when high, the counters advance by one |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Read data for `rd_addr` (combinational) |
| clr_en | input | 1 | Soft-interrupt clear strobe |
| clr_mask | input | 17 | Soft-interrupt bits to clear |
| softint | output | 17 | Soft-interrupt bits (bit 0 processor timer, bit 16 system timer) |
| timer_irq | output | 1 | Timer interrupt pulse |

## Verification
Counter values, soft-interrupt bits and the timer interrupt all change at the single clock edge that ends the stimulus cycle. The register read port is combinational, so a read settles in the same cycle as its address.

The bench drives every input just after a falling edge and holds it for one full cycle. It samples at the next falling edge, which reads the result of exactly one rising edge. To check that the interrupt is a one-cycle pulse, the bench runs one more idle cycle and samples again. The same-cycle conflicts are checked in that same one-edge window: a tick with a counter write, a tick with a compare write, and a match with a clear.

// File: rtl/tt_pkg.sv
// Shared constants for the tick timer unit.
// Assumes: three channels, addresses split into a compare flag (bit 2) and a channel index.
package tt_pkg;
    localparam int CNT_W   = 64;              // register width, top bit is the disable flag
    localparam int ADDR_W  = 3;               // register address width
    localparam int SINT_W  = 17;              // soft-interrupt vector width
    localparam int PT_BIT  = 0;               // processor timer soft-interrupt bit
    localparam int ST_BIT  = 16;              // system timer soft-interrupt bit
    localparam int NUM_CH  = 3;               // processor, system, hypervisor

    typedef enum logic [1:0] {
        CH_PROC  = 2'd0,
        CH_SYS   = 2'd1,
        CH_HYP   = 2'd2,
        CH_NONE  = 2'd3
    } tt_chan_e;
endpackage

// File: rtl/tt_channel.sv
// One compare-match tick channel: a (W-1)-bit free-running counter and a W-bit
// compare register whose top bit disables the match.
// Assumes: the counter write beats a tick in the same cycle; the compare write
// is only seen by later ticks; hit is combinational and registered by the user.
module tt_channel #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    localparam int VW = W - 1;
    localparam logic [W-1:0] CMP_RST = {1'b1, {VW{1'b0}}};

    logic [VW-1:0] cnt_r;
    logic [VW-1:0] cnt_inc;
    logic [W-1:0]  cmp_r;

    // Increment wraps naturally at the all-ones limit.
    assign cnt_inc = cnt_r + VW'(1);

    // Match on a counted tick with the compare enabled.
    assign hit = tick_en & ~cnt_we & ~cmp_r[W-1] & (cnt_inc == cmp_r[VW-1:0]);

    // Counter: a load wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_r <= '0;
        else if (cnt_we) cnt_r <= wr_data[VW-1:0];
        else if (tick_en) cnt_r <= cnt_inc;
    end

    // Compare register: resets disabled with a zero value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_r <= CMP_RST;
        else if (cmp_we) cmp_r <= wr_data;
    end

    assign cnt_q = {1'b0, cnt_r};
    assign cmp_q = cmp_r;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_we) |=> (cnt_q[VW-1:0] == $past(cnt_q[VW-1:0]) + VW'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_we) |=> $stable(cnt_q));

    // R1
    cmp_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmp_q == CMP_RST && cnt_q == '0));
endmodule

// File: rtl/tt_softint.sv
// Soft-interrupt register: two bits set by timer matches, all bits cleared by mask.
// Assumes: a set in the same cycle as a clear of that bit wins.
module tt_softint #(
    parameter int SW    = 17,
    parameter int A_BIT = 0,
    parameter int B_BIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_a,
    input  logic          set_b,
    input  logic          clr_en,
    input  logic [SW-1:0] clr_mask,
    output logic [SW-1:0] sint_q
);
    for (genvar b = 0; b < SW; b++) begin : g_bit
        logic set_this;
        if (b == A_BIT) begin : g_a
            assign set_this = set_a;
        end else if (b == B_BIT) begin : g_b
            assign set_this = set_b;
        end else begin : g_none
            assign set_this = 1'b0;
        end

        // One soft-interrupt bit: set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                     sint_q[b] <= 1'b0;
            else if (set_this)              sint_q[b] <= 1'b1;
            else if (clr_en && clr_mask[b]) sint_q[b] <= 1'b0;
        end
    end

    // R13
    clr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_mask[A_BIT] && !set_a) |=> !sint_q[A_BIT]);

    // R13
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_b |=> sint_q[B_BIT]);
endmodule

// File: rtl/tick_timer_unit.sv
// Three-channel compare-match tick timer with a flat register port,
// a soft-interrupt vector and a timer-interrupt pulse.
// Assumes: single clock domain; tick_en is a one-cycle period strobe.
module tick_timer_unit
    import tt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W,
    parameter int SW = SINT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          clr_en,
    input  logic [SW-1:0] clr_mask,
    output logic [SW-1:0] softint,
    output logic          timer_irq
);
    logic [W-1:0]      cnt_q [NUM_CH];
    logic [W-1:0]      cmp_q [NUM_CH];
    logic [NUM_CH-1:0] hits;
    logic              irq_r;
    tt_chan_e          wr_ch;
    tt_chan_e          rd_ch;

    assign wr_ch = tt_chan_e'(wr_addr[1:0]);
    assign rd_ch = tt_chan_e'(rd_addr[1:0]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en && (wr_ch == tt_chan_e'(c));
        tt_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .cnt_we  (sel && !wr_addr[2]),
            .cmp_we  (sel && wr_addr[2]),
            .wr_data (wr_data),
            .cnt_q   (cnt_q[c]),
            .cmp_q   (cmp_q[c]),
            .hit     (hits[c])
        );
    end

    tt_softint #(.SW(SW), .A_BIT(PT_BIT), .B_BIT(ST_BIT)) u_sint (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_a    (hits[CH_PROC]),
        .set_b    (hits[CH_SYS]),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .sint_q   (softint)
    );

    // Timer interrupt pulse: one cycle after any matching edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_r <= 1'b0;
        else        irq_r <= |hits;
    end
    assign timer_irq = irq_r;

    // Register read mux; the unused channel slot reads zero.
    always_comb begin
        case (rd_ch)
            CH_PROC: rd_data = rd_addr[2] ? cmp_q[0] : cnt_q[0];
            CH_SYS:  rd_data = rd_addr[2] ? cmp_q[1] : cnt_q[1];
            CH_HYP:  rd_data = rd_addr[2] ? cmp_q[2] : cnt_q[2];
            default: rd_data = '0;
        endcase
    end

    // R7
    all_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q[0][W-1] && cmp_q[1][W-1] && cmp_q[2][W-1]) |=> !timer_irq);

    // R8
    pt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(softint[PT_BIT]) |-> timer_irq);

    // R9
    st_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(softint[ST_BIT]) |-> timer_irq);

    // R10
    hyp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits == 3'b100 && !clr_en) |=> ($stable(softint) && timer_irq));
endmodule

// File: tb/tb_tick_timer_unit.sv
module tb_tick_timer_unit;
    localparam int PERIOD = 10;
    localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        clr_en = 1'b0;
    logic [16:0] clr_mask = '0;
    logic [16:0] softint;
    logic        timer_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    tick_timer_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .clr_en(clr_en), .clr_mask(clr_mask),
        .softint(softint), .timer_irq(timer_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied after a falling edge, sampled at the next one.
    task automatic cyc(input logic tk, input logic we, input logic [2:0] a,
                       input logic [63:0] d, input logic ce, input logic [16:0] m);
        tick_en = tk; wr_en = we; wr_addr = a; wr_data = d; clr_en = ce; clr_mask = m;
        @(negedge clk);
        tick_en = 0; wr_en = 0; clr_en = 0; clr_mask = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        cyc(0, 1, a, d, 0, '0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, '0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, '0);
    endtask

    function automatic logic [63:0] rd(input logic [2:0] a);
        rd_addr = a;
        return 64'(0);
    endfunction

    task automatic rdchk(input string req, input logic [2:0] a, input logic [63:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        for (int a = 0; a < 3; a++) rdchk("R1 counter", 3'(a), 64'd0);
        for (int a = 4; a < 7; a++) rdchk("R1 compare", 3'(a), DIS);
        chk("R1 softint", 64'(softint), 64'd0);
        chk("R1 irq", 64'(timer_irq), 64'd0);
    endtask

    task automatic t_count();
        do_reset();
        ticks(5);
        for (int a = 0; a < 3; a++) rdchk("R2 count", 3'(a), 64'd5);
        idle(); idle(); idle();
        rdchk("R2 hold", 3'd1, 64'd5);
        wr(3'd3, 64'h55); wr(3'd7, 64'h77);
        rdchk("R4 addr3 reads zero", 3'd3, 64'd0);
        rdchk("R4 addr7 reads zero", 3'd7, 64'd0);
        for (int a = 0; a < 3; a++) rdchk("R4 counter untouched", 3'(a), 64'd5);
        for (int a = 4; a < 7; a++) rdchk("R4 compare untouched", 3'(a), DIS);
    endtask

    task automatic t_wrap();
        do_reset();
        wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFE);
        rdchk("R2 bit63 not stored", 3'd1, 64'h7FFF_FFFF_FFFF_FFFE);
        ticks(1);
        rdchk("R3 at limit", 3'd1, 64'h7FFF_FFFF_FFFF_FFFF);
        ticks(1);
        rdchk("R3 wrap to zero", 3'd1, 64'd0);
    endtask

    task automatic t_proc();
        do_reset();
        wr(3'd0, 64'd10); wr(3'd4, 64'd13);
        ticks(2);
        chk("R6 no early irq", 64'(timer_irq), 64'd0);
        ticks(1);
        chk("R8 softint bit0", 64'(softint), 64'h1);
        chk("R8 irq", 64'(timer_irq), 64'd1);
        ticks(1);
        chk("R11 irq one cycle", 64'(timer_irq), 64'd0);
        chk("R8 softint held", 64'(softint), 64'h1);
    endtask

    task automatic t_dis();
        do_reset();
        wr(3'd0, 64'd10); wr(3'd4, DIS | 64'd11);
        ticks(1);
        rdchk("R7 counter reached", 3'd0, 64'd11);
        chk("R7 no irq", 64'(timer_irq), 64'd0);
        chk("R7 no softint", 64'(softint), 64'd0);
    endtask

    task automatic t_sys();
        do_reset();
        wr(3'd5, 64'd2);
        ticks(2);
        chk("R9 softint bit16", 64'(softint), 64'h1_0000);
        chk("R9 irq", 64'(timer_irq), 64'd1);
    endtask

    task automatic t_hyp();
        do_reset();
        wr(3'd4, 64'd1);
        ticks(1);
        chk("R10 setup softint", 64'(softint), 64'h1);
        wr(3'd2, 64'd40); wr(3'd6, 64'd41);
        ticks(1);
        chk("R10 irq", 64'(timer_irq), 64'd1);
        chk("R10 softint unchanged", 64'(softint), 64'h1);
    endtask

    task automatic t_cnt_wr();
        do_reset();
        wr(3'd4, 64'd6); wr(3'd0, 64'd2);
        cyc(1, 1, 3'd0, 64'd5, 0, '0);
        rdchk("R5 write beats tick", 3'd0, 64'd5);
        chk("R5 no match on write", 64'(timer_irq), 64'd0);
        ticks(1);
        chk("R6 match after load", 64'(timer_irq), 64'd1);
    endtask

    task automatic t_cmp_wr();
        do_reset();
        wr(3'd0, 64'd20);
        cyc(1, 1, 3'd4, 64'd21, 0, '0);
        rdchk("R12 counter advanced", 3'd0, 64'd21);
        chk("R12 old compare used", 64'(timer_irq), 64'd0);
        wr(3'd0, 64'd20);
        ticks(1);
        chk("R12 new compare used", 64'(timer_irq), 64'd1);
    endtask

    task automatic t_clr();
        do_reset();
        wr(3'd4, 64'd1); wr(3'd5, 64'd1);
        ticks(1);
        chk("R13 both set", 64'(softint), 64'h1_0001);
        cyc(0, 0, 0, 0, 1, 17'h0_0001);
        chk("R13 clear bit0", 64'(softint), 64'h1_0000);
        wr(3'd1, 64'd0);
        cyc(1, 0, 0, 0, 1, 17'h1_0000);
        chk("R13 set wins", 64'(softint), 64'h1_0000);
        cyc(0, 0, 0, 0, 1, 17'h1_FFFF);
        chk("R13 clear all", 64'(softint), 64'd0);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_count();
        t_wrap();
        t_proc();
        t_dis();
        t_sys();
        t_hyp();
        t_cnt_wr();
        t_cmp_wr();
        t_clr();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule